// File: doc/BRIEF.md
# Oscillator Detect with Reference Clock Fallback

This block decides which clock source drives the system once power-on reset is released. While reset is held low, both the external oscillator and the internal high-frequency reference are assumed to be running, and the system clock output stays low. After reset is released, the block runs one measurement window of `WIN` reference-clock cycles. During that window it counts oscillator activity. The oscillator is first divided down in its own domain. The divided signal is a toggle bit, and that bit is carried into the reference domain through a synchroniser. Each transition of the toggle bit is one tick, and one tick stands for 2^(DIV_W-1) oscillator rising edges.

At the end of the window the tick count is compared with the range `MIN_CNT`..`MAX_CNT`. A count inside the range selects the oscillator. A count outside the range, including no activity at all, selects the reference clock and raises a fail flag. The decision holds until the next power-on reset. The chosen clock is routed to the output through a glitch-free multiplexer. That multiplexer enables a source only on that source's falling edge, and only once every other source is off.

Top module: `osc_detect_fallback`

## Requirements
- R1: While rst_ni is low, sel_osc_o and osc_fail_o are 0 and sys_clk_o is held low, with both input clocks running.
- R2: The window starts counting at the release of rst_ni. sel_osc_o and osc_fail_o stay 0, and sys_clk_o stays low, through the first WIN-1 reference rising edges after the release. The decision appears on the WIN-th reference rising edge.
- R3: A tick count in the range MIN_CNT to MAX_CNT inclusive sets sel_osc_o=1 and osc_fail_o=0.
- R4: A tick count above MAX_CNT sets osc_fail_o=1 and sel_osc_o=0.
- R5: A tick count below MIN_CNT sets osc_fail_o=1 and sel_osc_o=0.
- R6: A stopped oscillator, with no edges during the window, gives osc_fail_o=1 and sel_osc_o=0.
- R7: sel_osc_o and osc_fail_o are never 1 together. Once either is set, it stays set until the next power-on reset, whatever the oscillator does afterwards.
- R8: After a decision, sys_clk_o follows the chosen clock: the oscillator when sel_osc_o=1, otherwise the reference. At most one source is enabled at a time, and a source is enabled only while every other source is off.
- R9: Each new power-on reset clears the decision and runs a fresh measurement, so a reference selection can be followed by an oscillator selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| osc_clk_i | input | 1 | External oscillator clock under test |
| ref_clk_i | input | 1 | Internal high-frequency reference clock |
| sys_clk_o | output | 1 | Glitch-free selected system clock |
| sel_osc_o | output | 1 | 1 when the oscillator has been chosen |
| osc_fail_o | output | 1 | Sticky flag: oscillator judged out of range, reference chosen |

## Verification
The assertions take two things for granted. First, the reference clock runs without interruption whenever reset is released. Second, the oscillator, when it runs, is slow enough for each toggle transition to be at least two reference periods long, so that no tick is lost in the synchroniser.

The stimulus respects both conditions. The reference is a steady 50 MHz clock, and the fastest oscillator used has a 10 ns period, which gives toggle transitions 40 ns apart.

Rates that pass are placed well inside MIN_CNT..MAX_CNT, and rates that fail are placed well outside it. This keeps the one-tick uncertainty from window alignment from flipping any expected outcome.

// File: rtl/odcf_pkg.sv
package odcf_pkg;
  typedef enum logic [1:0] {
    ODCF_MEAS = 2'd0,
    ODCF_OSC  = 2'd1,
    ODCF_REF  = 2'd2
  } odcf_state_e;

  localparam int unsigned ODCF_SRC_OSC = 0;
  localparam int unsigned ODCF_SRC_REF = 1;
  localparam int unsigned ODCF_NSRC    = 2;
endpackage

// File: rtl/odcf_tick_sync.sv
module odcf_tick_sync #(
  parameter int unsigned DIV_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic rst_ni,
  input  logic osc_clk_i,
  input  logic ref_clk_i,
  output logic tick_o
);
  localparam int unsigned CH_W = SYNC_STAGES + 1;

  logic [DIV_W-1:0] div_q;
  logic [CH_W-1:0]  chain_q;

  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + DIV_W'(1);
  end

  // last stage is only the previous value for edge detection
  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[CH_W-2:0], div_q[DIV_W-1]};
  end

  assign tick_o = chain_q[CH_W-1] ^ chain_q[CH_W-2];
endmodule

// File: rtl/odcf_window_judge.sv
module odcf_window_judge
  import odcf_pkg::*;
#(
  parameter int unsigned WIN     = 64,
  parameter int unsigned MIN_CNT = 16,
  parameter int unsigned MAX_CNT = 24
) (
  input  logic rst_ni,
  input  logic ref_clk_i,
  input  logic tick_i,
  output logic sel_osc_o,
  output logic osc_fail_o
);
  localparam int unsigned WIN_W = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int unsigned CNT_W = $clog2(MAX_CNT + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] CNT_LO  = CNT_W'(MIN_CNT);
  localparam logic [CNT_W-1:0] CNT_HI  = CNT_W'(MAX_CNT);

  odcf_state_e      state_q;
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             win_last;
  logic             in_range;

  always_comb begin
    cnt_nxt = cnt_q;
    if (tick_i && (cnt_q != CNT_SAT)) cnt_nxt = cnt_q + CNT_W'(1);
  end

  assign win_last = (state_q == ODCF_MEAS) && (win_q == WIN_W'(WIN - 1));
  assign in_range = (cnt_nxt >= CNT_LO) && (cnt_nxt <= CNT_HI);

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ODCF_MEAS;
      win_q   <= '0;
      cnt_q   <= '0;
    end else if (state_q == ODCF_MEAS) begin
      win_q <= win_q + WIN_W'(1);
      cnt_q <= cnt_nxt;
      if (win_last) state_q <= in_range ? ODCF_OSC : ODCF_REF;
    end
  end

  assign sel_osc_o  = (state_q == ODCF_OSC);
  assign osc_fail_o = (state_q == ODCF_REF);

  // R7
  not_both_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !(sel_osc_o && osc_fail_o));
  // R7
  fail_sticky_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    osc_fail_o |=> osc_fail_o);
  // R7
  sel_sticky_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    sel_osc_o |=> sel_osc_o);
  // R3
  pass_sel_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (win_last && (cnt_nxt >= CNT_LO) && (cnt_nxt <= CNT_HI)) |=> sel_osc_o);
  // R4
  over_fail_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (win_last && (cnt_nxt > CNT_HI)) |=> osc_fail_o);
  // R5
  under_fail_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (win_last && (cnt_nxt < CNT_LO)) |=> osc_fail_o);
  // R2
  early_hold_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (state_q == ODCF_MEAS && !win_last) |=> (!sel_osc_o && !osc_fail_o));
endmodule

// File: rtl/odcf_clk_mux.sv
module odcf_clk_mux #(
  parameter int unsigned NSRC        = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            rst_ni,
  input  logic [NSRC-1:0] clk_i,
  input  logic [NSRC-1:0] req_i,
  output logic [NSRC-1:0] en_o,
  output logic            clk_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   en_q;
    logic                   others_on;

    assign others_on = |(en_o & ~(NSRC'(1) << g));

    always_ff @(posedge clk_i[g] or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= {sync_q[SYNC_STAGES-2:0], req_i[g] & ~others_on};
    end

    // enable changes only while this clock is low
    always_ff @(negedge clk_i[g] or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b0;
      else         en_q <= sync_q[SYNC_STAGES-1];
    end

    assign en_o[g] = en_q;

    // R8
    break_before_make_chk: assert property (@(negedge clk_i[g]) disable iff (!rst_ni)
      $rose(en_q) |-> !others_on);
  end

  always_comb clk_o = |(clk_i & en_o);

  // R8
  one_src_chk: assert property (@(posedge clk_i[NSRC-1]) disable iff (!rst_ni)
    $onehot0(en_o));
endmodule

// File: rtl/osc_detect_fallback.sv
module osc_detect_fallback
  import odcf_pkg::*;
#(
  parameter int unsigned WIN         = 64,
  parameter int unsigned MIN_CNT     = 16,
  parameter int unsigned MAX_CNT     = 24,
  parameter int unsigned DIV_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic rst_ni,
  input  logic osc_clk_i,
  input  logic ref_clk_i,
  output logic sys_clk_o,
  output logic sel_osc_o,
  output logic osc_fail_o
);
  logic                 tick;
  logic [ODCF_NSRC-1:0] src_clk;
  logic [ODCF_NSRC-1:0] src_req;
  logic [ODCF_NSRC-1:0] src_en;

  odcf_tick_sync #(
    .DIV_W       (DIV_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_tick (
    .rst_ni    (rst_ni),
    .osc_clk_i (osc_clk_i),
    .ref_clk_i (ref_clk_i),
    .tick_o    (tick)
  );

  odcf_window_judge #(
    .WIN     (WIN),
    .MIN_CNT (MIN_CNT),
    .MAX_CNT (MAX_CNT)
  ) u_judge (
    .rst_ni     (rst_ni),
    .ref_clk_i  (ref_clk_i),
    .tick_i     (tick),
    .sel_osc_o  (sel_osc_o),
    .osc_fail_o (osc_fail_o)
  );

  assign src_clk[ODCF_SRC_OSC] = osc_clk_i;
  assign src_clk[ODCF_SRC_REF] = ref_clk_i;
  assign src_req[ODCF_SRC_OSC] = sel_osc_o;
  assign src_req[ODCF_SRC_REF] = osc_fail_o;

  odcf_clk_mux #(
    .NSRC        (ODCF_NSRC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_mux (
    .rst_ni (rst_ni),
    .clk_i  (src_clk),
    .req_i  (src_req),
    .en_o   (src_en),
    .clk_o  (sys_clk_o)
  );

  // R8
  osc_en_needs_sel_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    src_en[ODCF_SRC_OSC] |-> sel_osc_o);
  // R8
  ref_en_needs_fail_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    src_en[ODCF_SRC_REF] |-> osc_fail_o);
endmodule

// File: tb/tb_osc_detect_fallback.sv
`timescale 1ns/1ps
module tb_osc_detect_fallback;
  localparam int unsigned WIN = 64;
  localparam int NV = 7;
  // oscillator half period in ps; code 0 pass, 1 too fast, 2 too slow
  localparam int HALF_PS[NV] = '{8000, 5000, 20000, 7500, 6000, 9000, 11000};
  localparam int CODE[NV]    = '{0, 1, 2, 0, 1, 0, 2};

  logic rst_ni = 1'b0;
  logic osc_clk = 1'b0;
  logic ref_clk = 1'b0;
  logic sys_clk, sel_osc, osc_fail;
  int   osc_half_ps = 8000;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  osc_detect_fallback #(.WIN(WIN), .MIN_CNT(16), .MAX_CNT(24), .DIV_W(3), .SYNC_STAGES(2)) dut (
    .rst_ni(rst_ni), .osc_clk_i(osc_clk), .ref_clk_i(ref_clk),
    .sys_clk_o(sys_clk), .sel_osc_o(sel_osc), .osc_fail_o(osc_fail)
  );

  always #10 ref_clk = ~ref_clk;

  always begin
    if (osc_half_ps == 0) begin
      osc_clk = 1'b0;
      #10;
    end else begin
      #(osc_half_ps / 1000.0);
      osc_clk = ~osc_clk;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // count mismatches of sys_clk against the chosen source over several periods
  task automatic follow(input string req, input bit use_osc);
    int bad = 0;
    for (int i = 0; i < 8; i++) begin
      if (use_osc) begin
        @(posedge osc_clk); #1; if (sys_clk !== 1'b1) bad++;
        @(negedge osc_clk); #1; if (sys_clk !== 1'b0) bad++;
      end else begin
        @(posedge ref_clk); #1; if (sys_clk !== 1'b1) bad++;
        @(negedge ref_clk); #1; if (sys_clk !== 1'b0) bad++;
      end
    end
    chk(req, bad, 0);
  endtask

  task automatic run_case(input int half, input bit exp_sel, input string req);
    int low_seen = 0;
    rst_ni = 1'b0;
    osc_half_ps = half;
    for (int i = 0; i < 10; i++) begin
      @(posedge ref_clk); #3;
      if (sys_clk !== 1'b0) low_seen++;
    end
    chk("R1 sel", sel_osc, 0);
    chk("R1 fail", osc_fail, 0);
    chk("R1 clk low", low_seen, 0);
    @(negedge ref_clk);
    rst_ni = 1'b1;
    repeat (WIN - 1) @(posedge ref_clk);
    #5;
    chk("R2 undecided", {30'd0, sel_osc, osc_fail}, 0);
    chk("R2 clk low", sys_clk, 0);
    @(posedge ref_clk);
    #5;
    chk({req, " sel"}, sel_osc, exp_sel);
    chk({req, " fail"}, osc_fail, !exp_sel);
    repeat (20) @(posedge ref_clk);
    follow("R8 follow", exp_sel);
  endtask

  initial begin
    string tag;
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    string tag;
    for (int v = 0; v < NV; v++) begin
      tag = (CODE[v] == 0) ? "R3" : (CODE[v] == 1) ? "R4" : "R5";
      run_case(HALF_PS[v], CODE[v] == 0, tag);
      // R7: change oscillator rate after the decision; result must hold
      osc_half_ps = (CODE[v] == 0) ? 20000 : 8000;
      repeat (200) @(posedge ref_clk);
      #5;
      chk("R7 sticky sel", sel_osc, CODE[v] == 0);
      chk("R7 sticky fail", osc_fail, CODE[v] != 0);
    end

    // R6: stopped oscillator
    run_case(0, 1'b0, "R6");

    // R9: fresh reset after a fallback selects a good oscillator
    run_case(8000, 1'b1, "R9");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule